// File: doc/BRIEF.md
# S/PDIF Channel Status Capture

The block assembles the 192-bit channel status block that an S/PDIF stream carries one bit per subframe. It sits behind a biphase decoder and preamble detector and sees each decoded subframe as a single-cycle strobe with three attributes: the status bit, the channel the subframe belongs to (A or B) and a flag marking the first subframe of a block. A software control bit decides which channel feeds the capture; subframes of the other channel are ignored.

Bits are stored in arrival order, starting at the flagged subframe, LSB-first within each byte. Once all 192 bits of a block have arrived, the whole block is copied at once into a held register, so the readable value never mixes two blocks. A block-start flag that arrives early abandons the partial block and starts again at bit 0. Software reads the held block through a 3-bit word select as six 32-bit words.

Top module: `cs_capture`

## Requirements
- R1: While rst_ni is low, and after it rises with no complete block yet gathered, every word read returns zero.
- R2: Status bit n of a block (n counted from 0 at the block-start subframe) ends up in byte n/8, bit n%8, and word w of the read port carries byte 4w+j in bits 8j+7 down to 8j.
- R3: With src_chan_b_i = 0 only subframes with sf_chan_b_i = 0 (channel A) are captured; with src_chan_b_i = 1 only subframes with sf_chan_b_i = 1 (channel B); subframes of the other channel have no effect.
- R4: The readable block changes only in the cycle after the 192nd bit of a block is accepted; until then every word keeps showing the previous complete block.
- R5: A block-start subframe on the selected channel arriving before 192 bits are gathered discards the partial block and restarts gathering at bit 0.
- R6: Word select values 6 and 7 return zero.
- R7: Selected-channel subframes without the block-start flag that arrive while no block is being gathered (before the first start, or after a block completed) are ignored.
- R8: While sf_valid_i is low, the values on sf_chan_b_i, sf_start_i and sf_cs_bit_i have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sf_valid_i | input | 1 | One-cycle strobe: a decoded subframe is present |
| sf_chan_b_i | input | 1 | Subframe channel: 0 = A, 1 = B |
| sf_start_i | input | 1 | Subframe is the first of a 192-frame block |
| sf_cs_bit_i | input | 1 | Channel status bit carried by the subframe |
| src_chan_b_i | input | 1 | Capture source: 0 = channel A, 1 = channel B |
| word_sel_i | input | 3 | Word select, 0..5 valid |
| word_o | output | 32 | Selected word of the held block |

## Verification
A subframe strobe is registered on the rising edge where sf_valid_i is high, and the held block, being read through a purely combinational select, shows a completed block right after the edge that accepts its 192nd bit. The bench therefore drives each strobe on a falling edge, lets exactly one rising edge consume it, and reads the words on the following falling edge with the strobe dropped, stepping the word select in small delays inside that quiet window. Mid-block reads made the same way confirm the previous block is still shown, and the other channel, idle cycles with noisy attributes and stray bits after completion are interleaved into the same stream so each has to leave the final words unchanged.

// File: rtl/cs_cap_pkg.sv
`timescale 1ns/1ps
package cs_cap_pkg;
  localparam int unsigned CS_BITS = 192;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned N_WORDS = CS_BITS / WORD_W;
  localparam int unsigned IDX_W   = $clog2(CS_BITS);
endpackage

// File: rtl/cs_collector.sv
`timescale 1ns/1ps
module cs_collector #(
  parameter int unsigned CS_BITS = cs_cap_pkg::CS_BITS,
  parameter int unsigned IDX_W   = $clog2(CS_BITS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               take_i,
  input  logic               start_i,
  input  logic               bit_i,
  output logic               commit_o,
  output logic [CS_BITS-1:0] blk_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CS_BITS - 1);

  logic               armed_q;
  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   wr_idx;
  logic               wr_en;
  logic [CS_BITS-1:0] stage_q, stage_d;

  always_comb begin
    wr_idx  = start_i ? '0 : idx_q;
    // start always (re)arms; plain bits only count while armed
    wr_en   = take_i && (start_i || armed_q);
    stage_d = stage_q;
    if (wr_en) stage_d[wr_idx] = bit_i;
    commit_o = wr_en && (wr_idx == LAST);
  end

  assign blk_o = stage_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      idx_q   <= '0;
      stage_q <= '0;
    end else if (wr_en) begin
      stage_q <= stage_d;
      if (commit_o) begin
        armed_q <= 1'b0;
        idx_q   <= '0;
      end else begin
        armed_q <= 1'b1;
        idx_q   <= wr_idx + 1'b1;
      end
    end
  end

  assert_idx_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST);

  assert_single_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);

  assert_unarmed_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !start_i) |=> $stable(stage_q));
endmodule

// File: rtl/cs_hold.sv
`timescale 1ns/1ps
module cs_hold #(
  parameter int unsigned CS_BITS = cs_cap_pkg::CS_BITS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               commit_i,
  input  logic [CS_BITS-1:0] blk_i,
  output logic [CS_BITS-1:0] held_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       held_o <= '0;
    else if (commit_i) held_o <= blk_i;
  end

  assert_held_atomic_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(held_o));
endmodule

// File: rtl/cs_word_mux.sv
`timescale 1ns/1ps
module cs_word_mux #(
  parameter int unsigned CS_BITS = cs_cap_pkg::CS_BITS,
  parameter int unsigned WORD_W  = cs_cap_pkg::WORD_W,
  parameter int unsigned SEL_W   = cs_cap_pkg::SEL_W
) (
  input  logic [CS_BITS-1:0] blk_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [WORD_W-1:0]  word_o
);
  localparam int unsigned N_WORDS = CS_BITS / WORD_W;

  logic [WORD_W-1:0] words [N_WORDS];

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    assign words[w] = blk_i[w*WORD_W +: WORD_W];
  end

  always_comb begin
    word_o = '0;
    for (int w = 0; w < N_WORDS; w++)
      if (sel_i == SEL_W'(w)) word_o = words[w];
  end

  always_comb begin
    if (sel_i >= SEL_W'(N_WORDS))
      assert_unused_sel_zero_R6: assert (word_o == '0);
  end
endmodule

// File: rtl/cs_capture.sv
`timescale 1ns/1ps
module cs_capture
  import cs_cap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sf_valid_i,
  input  logic              sf_chan_b_i,
  input  logic              sf_start_i,
  input  logic              sf_cs_bit_i,
  input  logic              src_chan_b_i,
  input  logic [SEL_W-1:0]  word_sel_i,
  output logic [WORD_W-1:0] word_o
);
  logic               take;
  logic               commit;
  logic [CS_BITS-1:0] blk;
  logic [CS_BITS-1:0] held;

  assign take = sf_valid_i && (sf_chan_b_i == src_chan_b_i);

  cs_collector #(.CS_BITS(CS_BITS), .IDX_W(IDX_W)) u_collect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (take),
    .start_i  (sf_start_i),
    .bit_i    (sf_cs_bit_i),
    .commit_o (commit),
    .blk_o    (blk)
  );

  cs_hold #(.CS_BITS(CS_BITS)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .blk_i    (blk),
    .held_o   (held)
  );

  cs_word_mux #(.CS_BITS(CS_BITS), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_mux (
    .blk_i  (held),
    .sel_i  (word_sel_i),
    .word_o (word_o)
  );

  assert_idle_no_effect_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sf_valid_i |=> $stable(held));

  assert_other_chan_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sf_valid_i && (sf_chan_b_i != src_chan_b_i)) |=> $stable(held));
endmodule

// File: tb/cs_capture_tb_top.sv
`timescale 1ns/1ps
module cs_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sf_valid = 1'b0, sf_chan_b = 1'b0, sf_start = 1'b0, sf_bit = 1'b0;
  logic        src_b = 1'b0;
  logic [2:0]  sel = '0;
  logic [31:0] word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cs_capture dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sf_valid_i(sf_valid), .sf_chan_b_i(sf_chan_b),
    .sf_start_i(sf_start), .sf_cs_bit_i(sf_bit), .src_chan_b_i(src_b),
    .word_sel_i(sel), .word_o(word)
  );

  function automatic logic [191:0] mk(input logic [7:0] base, input logic [7:0] step);
    logic [191:0] r;
    for (int k = 0; k < 24; k++) r[k*8 +: 8] = base + 8'(k) * step;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: sel=%0d actual %h expected %h", req, sel, act, exp);
    end
  endtask

  task automatic ev(input logic chb, input logic st, input logic b);
    @(negedge clk);
    sf_valid = 1'b1; sf_chan_b = chb; sf_start = st; sf_bit = b;
  endtask

  task automatic idle();
    @(negedge clk);
    sf_valid = 1'b0; sf_start = 1'b0; sf_bit = 1'b0;
  endtask

  task automatic check_words(input string req, input logic [191:0] e);
    idle();
    for (int w = 0; w < 8; w++) begin
      sel = 3'(w);
      #0.4;
      check(req, word, (w < 6) ? e[w*32 +: 32] : 32'h0);
    end
  endtask

  task automatic send_range(input logic [191:0] d, input logic chb,
                            input int lo, input int hi, input bit inter);
    for (int i = lo; i <= hi; i++) begin
      ev(chb, i == 0, d[i]);
      if (inter) ev(~chb, i == 0, ~d[i]);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_words("R1 in reset", '0);
    rst_n = 1'b1;
    check_words("R1 after reset", '0);
  endtask

  // R2 byte order, R3 channel A, R4 no partial update
  task automatic t_byte_order();
    logic [191:0] p = mk(8'h10, 8'h01);
    src_b = 1'b0;
    send_range(p, 1'b0, 0, 99, 1'b1);
    check_words("R4 mid block", '0);
    send_range(p, 1'b0, 100, 191, 1'b1);
    check_words("R2 block A", p);
    sel = 3'd0; #0.4; check("R2 word0 bytes", word, 32'h13121110);
    sel = 3'd5; #0.4; check("R2 word5 bytes", word, 32'h27262524);
  endtask

  task automatic t_src_b(output logic [191:0] p);
    p = mk(8'h5a, 8'h25);
    src_b = 1'b1;
    send_range(p, 1'b1, 0, 191, 1'b1);
    check_words("R3 channel B", p);
  endtask

  task automatic t_restart(input logic [191:0] prev, output logic [191:0] p4);
    logic [191:0] p3 = mk(8'hc3, 8'h3b);
    p4 = mk(8'h27, 8'h61);
    send_range(p3, 1'b1, 0, 59, 1'b1);
    check_words("R4 previous kept", prev);
    send_range(p4, 1'b1, 0, 191, 1'b0);
    check_words("R5 restart", p4);
  endtask

  task automatic t_unarmed(input logic [191:0] prev);
    logic [191:0] p = mk(8'h9e, 8'h17);
    send_range(p, 1'b1, 1, 191, 1'b0);
    check_words("R7 stray bits", prev);
  endtask

  task automatic t_valid();
    logic [191:0] p = mk(8'h81, 8'h0d);
    src_b = 1'b0;
    for (int i = 0; i < 192; i++) begin
      ev(1'b0, i == 0, p[i]);
      @(negedge clk);
      sf_valid = 1'b0; sf_chan_b = 1'b0; sf_start = 1'b1; sf_bit = ~p[i];
    end
    check_words("R8 idle noise", p);
  endtask

  task automatic t_reset_mid();
    logic [191:0] p = mk(8'h44, 8'h0b);
    send_range(p, 1'b0, 0, 99, 1'b0);
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check_words("R1 reset mid block", '0);
    send_range(p, 1'b0, 1, 191, 1'b0);
    check_words("R7 after reset", '0);
    send_range(p, 1'b0, 0, 191, 1'b0);
    check_words("R2 after reset", p);
  endtask

  initial begin
    logic [191:0] pb, p4;
    t_reset();
    t_byte_order();
    t_src_b(pb);
    t_restart(pb, p4);
    t_unarmed(p4);
    t_valid();
    t_reset_mid();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule